// File: doc/BRIEF.md
# Latching Multichannel Event Counter Bank

This block holds a bank of independent edge counters, one per input channel. Every channel input is treated as asynchronous. It passes through a two-stage synchroniser and a rising-edge detector, so each leading edge adds exactly one to that channel's counter. When a single-cycle trigger arrives, every enabled counter is copied into its own shadow latch in the same clock cycle. Counting carries on without a pause. In auto-clear mode the counters restart from zero at each trigger, so the latched values become per-interval counts rather than running totals.

Each counter runs at either a narrow or a wide depth. By default these are 32 and 64 bits, and both are parameters. A single shared auxiliary input can be given one of three roles: freezing all counters, acting as a common test stimulus that advances every enabled channel, or holding all counters at zero. A host port reads the low narrow half of any live counter at any time. A second host port reads the full latched value of any channel. A host clear command zeroes all live counters. Synchronous pulse rates are limited to at most half the counting clock.

Top module: `evc_bank`

## Requirements
- R1: A counter advances by one for each rising edge of its channel input, seen three clock edges after the input change. An input that stays high adds only one count.
- R2: A trigger copies the current value of every enabled counter into that channel's latch in the same cycle. Counting is not stalled, and latches hold their value between triggers.
- R3: With `cfg_wide`=0, a counter wraps modulo 2^HALF_W and its upper part reads zero. With `cfg_wide`=1, it carries into the upper part and wraps modulo 2^CNT_W.
- R4: With `cfg_auto_rst`=1, a trigger clears every counter after its value has been latched. An edge in the trigger cycle is counted into the new interval, which leaves the counter at 1.
- R5: With `cfg_aux_mode`=1, while the synchronised auxiliary level is high no counter changes, and channel and test edges are dropped.
- R6: With `cfg_aux_mode`=2, each rising edge of the auxiliary input advances every enabled counter by one. An auxiliary edge and a channel edge in the same cycle add one, not two.
- R7: With `cfg_aux_mode`=3, all counters are held at zero while the synchronised auxiliary level is high.
- R8: A `host_clr` pulse zeroes all live counters in the next cycle and leaves the latches unchanged.
- R9: A channel whose `cfg_mask` bit is 0 ignores edges and keeps its count, though clears still apply. A trigger writes zero into its latch.
- R10: `rd_live` shows the low HALF_W bits of the counter chosen by `rd_sel`. `lat_data` shows the latch chosen by `lat_sel`. Both are combinational reads that are available at any time.
- R11: After reset, all counters, latches and synchroniser stages are zero.
- R12: With `cfg_aux_mode`=0, the auxiliary input has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_in | input | NCH | Asynchronous channel pulse inputs |
| aux_in | input | 1 | Asynchronous shared auxiliary input |
| trig_in | input | 1 | Synchronous single-cycle latch trigger |
| host_clr | input | 1 | Synchronous clear of all live counters |
| cfg_mask | input | NCH | Per-channel enable |
| cfg_wide | input | 1 | 1 selects the wide counting depth |
| cfg_auto_rst | input | 1 | 1 clears counters on every trigger |
| cfg_aux_mode | input | 2 | Auxiliary role: 0 off, 1 freeze, 2 test, 3 clear |
| rd_sel | input | SEL_W | Channel for the live read |
| rd_live | output | HALF_W | Low half of the selected live counter |
| lat_sel | input | SEL_W | Channel for the latched read |
| lat_data | output | CNT_W | Selected latched value |

## Verification
The hardest conditions to reach are the wrap points. These are the narrow-mode rollover and the carry into the upper half in wide mode, and at the default depths they need billions of edges. The bench therefore builds the block with a 6-bit narrow half and a 12-bit full width. It then drives every channel with a square wave at the maximum allowed rate, so both wrap points arrive within a few hundred cycles. Trigger-coincident edges under auto-clear come from a phase that toggles all inputs on every cycle while triggers fire often.

// File: rtl/evc_pkg.sv
// Shared definitions for the event counter bank.
package evc_pkg;
    // Role selected for the shared auxiliary input.
    typedef enum logic [1:0] {
        AUX_OFF    = 2'd0,
        AUX_FREEZE = 2'd1,
        AUX_TEST   = 2'd2,
        AUX_CLEAR  = 2'd3
    } aux_mode_e;
endpackage

// File: rtl/evc_sync_edge.sv
// Two-flop synchroniser followed by a rising-edge detector.
// Assumes: input pulses stay high or low for at least one clock period.
module evc_sync_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q, stab_q, prev_q;

    // Resample the asynchronous inputs and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    // Present the stable level and the low-to-high transition.
    always_comb begin
        level = stab_q;
        rise  = stab_q & ~prev_q;
    end
endmodule

// File: rtl/evc_aux_ctrl.sv
// Decodes the shared auxiliary input into freeze, test-pulse and clear strobes.
// Assumes: the auxiliary input is asynchronous; the mode is quasi-static.
module evc_aux_ctrl
    import evc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       aux_in,
    input  logic [1:0] mode,
    output logic       hold,
    output logic       test_pulse,
    output logic       clr
);
    logic aux_lvl, aux_rise;
    aux_mode_e mode_e;

    evc_sync_edge #(.W(1)) u_aux_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (aux_in),
        .level    (aux_lvl),
        .rise     (aux_rise)
    );

    // Route the synchronised auxiliary signal to the role chosen by the mode.
    always_comb begin
        mode_e     = aux_mode_e'(mode);
        hold       = 1'b0;
        test_pulse = 1'b0;
        clr        = 1'b0;
        case (mode_e)
            AUX_FREEZE: hold       = aux_lvl;
            AUX_TEST:   test_pulse = aux_rise;
            AUX_CLEAR:  clr        = aux_lvl;
            default:    ;
        endcase
    end
endmodule

// File: rtl/evc_channel.sv
// One counting channel: a counter that is CNT_W bits wide at most, plus a shadow latch.
// Assumes: rise/test_pulse are single-cycle strobes; trig is synchronous.
module evc_channel #(
    parameter int CNT_W  = 64,
    parameter int HALF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rise,
    input  logic             test_pulse,
    input  logic             hold,
    input  logic             clear,
    input  logic             trig,
    input  logic             auto_rst,
    input  logic             wide,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] lat
);
    localparam int UP_W = CNT_W - HALF_W;

    logic             inc;
    logic [CNT_W-1:0] base, sum, cnt_nxt;

    // Next counter value: clear wins, then auto-clear base, then depth fold.
    always_comb begin
        inc  = en & ~hold & (rise | test_pulse);
        base = (trig & auto_rst) ? '0 : cnt;
        sum  = base + CNT_W'(inc);
        if (clear)
            cnt_nxt = '0;
        else if (wide)
            cnt_nxt = sum;
        else
            cnt_nxt = {{UP_W{1'b0}}, sum[HALF_W-1:0]};
    end

    // Counter register, updated every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    // Shadow latch, loaded with the pre-update value on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)    lat <= '0;
        else if (trig) lat <= en ? cnt : '0;
    end
endmodule

// File: rtl/evc_bank.sv
// Bank of NCH latching edge counters with a shared auxiliary control input.
// Assumes: trig_in and host_clr are synchronous to clk; ch_in/aux_in are not.
module evc_bank #(
    parameter int NCH    = 32,
    parameter int CNT_W  = 64,
    parameter int HALF_W = 32,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    ch_in,
    input  logic              aux_in,
    input  logic              trig_in,
    input  logic              host_clr,
    input  logic [NCH-1:0]    cfg_mask,
    input  logic              cfg_wide,
    input  logic              cfg_auto_rst,
    input  logic [1:0]        cfg_aux_mode,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [HALF_W-1:0] rd_live,
    input  logic [SEL_W-1:0]  lat_sel,
    output logic [CNT_W-1:0]  lat_data
);
    logic [NCH-1:0] ch_lvl, ch_rise;
    logic           aux_hold, aux_test, aux_clear, any_clear;
    logic [NCH-1:0][CNT_W-1:0] cnt_all, lat_all;

    evc_sync_edge #(.W(NCH)) u_ch_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ch_in),
        .level    (ch_lvl),
        .rise     (ch_rise)
    );

    evc_aux_ctrl u_aux (
        .clk        (clk),
        .rst_n      (rst_n),
        .aux_in     (aux_in),
        .mode       (cfg_aux_mode),
        .hold       (aux_hold),
        .test_pulse (aux_test),
        .clr        (aux_clear)
    );

    // Combine the host and auxiliary clear sources.
    always_comb any_clear = host_clr | aux_clear;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        evc_channel #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (cfg_mask[g]),
            .rise       (ch_rise[g]),
            .test_pulse (aux_test),
            .hold       (aux_hold),
            .clear      (any_clear),
            .trig       (trig_in),
            .auto_rst   (cfg_auto_rst),
            .wide       (cfg_wide),
            .cnt        (cnt_all[g]),
            .lat        (lat_all[g])
        );
    end

    // Host read multiplexers; out-of-range selects return zero.
    always_comb begin
        rd_live  = '0;
        lat_data = '0;
        if (int'(rd_sel) < NCH)  rd_live  = cnt_all[rd_sel][HALF_W-1:0];
        if (int'(lat_sel) < NCH) lat_data = lat_all[lat_sel];
    end
endmodule

// File: rtl/evc_bank_chk.sv
// Property checker for evc_bank, attached by bind below.
module evc_bank_chk #(
    parameter int NCH    = 32,
    parameter int CNT_W  = 64,
    parameter int HALF_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      trig_in,
    input logic                      host_clr,
    input logic                      cfg_wide,
    input logic                      cfg_auto_rst,
    input logic [NCH-1:0]            cfg_mask,
    input logic                      aux_hold,
    input logic                      aux_clear,
    input logic [NCH-1:0][CNT_W-1:0] cnt_all,
    input logic [NCH-1:0][CNT_W-1:0] lat_all
);
    // R2: latches move only on a trigger
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(trig_in) |-> $stable(lat_all));

    // R8: host clear empties every counter
    p_host_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_clr) |-> (cnt_all == '0));

    // R7: auxiliary clear level empties every counter
    p_aux_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(aux_clear) |-> (cnt_all == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R9: a disabled channel latches zero
        p_mask_lat_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(trig_in) && !$past(cfg_mask[i])) |-> (lat_all[i] == '0));

        // R3: narrow depth keeps the upper part empty
        p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(cfg_wide) |-> (cnt_all[i][CNT_W-1:HALF_W] == '0));

        // R4: after an auto-clearing trigger a counter holds at most one
        p_auto_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(trig_in && cfg_auto_rst) |-> (cnt_all[i] <= CNT_W'(1)));

        // R5: freeze keeps counters still when nothing clears them
        p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(aux_hold) && !$past(host_clr) && $past(cfg_wide)
             && !$past(trig_in && cfg_auto_rst)) |-> $stable(cnt_all[i]));
    end
endmodule

bind evc_bank evc_bank_chk #(.NCH(NCH), .CNT_W(CNT_W), .HALF_W(HALF_W)) u_evc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_in      (trig_in),
    .host_clr     (host_clr),
    .cfg_wide     (cfg_wide),
    .cfg_auto_rst (cfg_auto_rst),
    .cfg_mask     (cfg_mask),
    .aux_hold     (aux_hold),
    .aux_clear    (aux_clear),
    .cnt_all      (cnt_all),
    .lat_all      (lat_all)
);

// File: tb/evc_bank_tb_top.sv
`timescale 1ns/1ps
module evc_bank_tb_top;
    localparam int NCH = 8, CNT_W = 12, HALF_W = 6, SEL_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] ch_in = '0, cfg_mask = '1;
    logic aux_in = 1'b0, trig_in = 1'b0, host_clr = 1'b0;
    logic cfg_wide = 1'b1, cfg_auto_rst = 1'b0;
    logic [1:0] cfg_aux_mode = 2'd0;
    logic [SEL_W-1:0] rd_sel = '0, lat_sel = '0;
    logic [HALF_W-1:0] rd_live;
    logic [CNT_W-1:0] lat_data;

    int vectors = 0, miscompares = 0;
    string cur_req = "R11";
    int ch_pat = 0, aux_pat = 0, trig_div = 0, clr_div = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evc_bank #(.NCH(NCH), .CNT_W(CNT_W), .HALF_W(HALF_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .aux_in(aux_in),
        .trig_in(trig_in), .host_clr(host_clr), .cfg_mask(cfg_mask),
        .cfg_wide(cfg_wide), .cfg_auto_rst(cfg_auto_rst),
        .cfg_aux_mode(cfg_aux_mode), .rd_sel(rd_sel), .rd_live(rd_live),
        .lat_sel(lat_sel), .lat_data(lat_data)
    );

    // Behavioural reference: input history queues and integer counts.
    longint unsigned m_cnt [NCH];
    longint unsigned m_lat [NCH];
    logic [NCH-1:0] chq [$];
    logic aq [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin m_cnt[i] = 0; m_lat[i] = 0; end
            chq = '{'0, '0, '0};
            aq  = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit hold, tst, aclr;
            hold = (cfg_aux_mode == 2'd1) && aq[1];
            tst  = (cfg_aux_mode == 2'd2) && aq[1] && !aq[2];
            aclr = (cfg_aux_mode == 2'd3) && aq[1];
            for (int i = 0; i < NCH; i++) begin
                bit ed, inc;
                longint unsigned n;
                ed  = chq[1][i] && !chq[2][i];
                inc = cfg_mask[i] && !hold && (ed || tst);
                if (trig_in) m_lat[i] = cfg_mask[i] ? m_cnt[i] : 0;
                if (host_clr || aclr) n = 0;
                else begin
                    n = (trig_in && cfg_auto_rst) ? 0 : m_cnt[i];
                    n = n + (inc ? 1 : 0);
                    n = cfg_wide ? (n % (64'd1 << CNT_W)) : (n % (64'd1 << HALF_W));
                end
                m_cnt[i] = n;
            end
            chq.push_front(ch_in); void'(chq.pop_back());
            aq.push_front(aux_in); void'(aq.pop_back());
        end
    end

    // Compare both read ports against the model.
    task automatic compare();
        longint unsigned el, ed;
        el = m_cnt[rd_sel] % (64'd1 << HALF_W);
        ed = m_lat[lat_sel];
        vectors++;
        if (rd_live !== HALF_W'(el)) begin
            miscompares++;
            $display("FAIL %s live ch%0d got %h exp %h", cur_req, rd_sel, rd_live, HALF_W'(el));
        end
        if (lat_data !== CNT_W'(ed)) begin
            miscompares++;
            $display("FAIL %s latch ch%0d got %h exp %h", cur_req, lat_sel, lat_data, CNT_W'(ed));
        end
    endtask

    // One cycle: check at the falling edge, then drive the next inputs.
    task automatic step();
        @(negedge clk);
        compare();
        rd_sel  = SEL_W'((int'(rd_sel) + 1) % NCH);
        lat_sel = SEL_W'((int'(lat_sel) + 3) % NCH);
        case (ch_pat)
            0: ch_in = NCH'($urandom);
            1: ch_in = ~ch_in;
            2: ch_in = '1;
            default: ch_in = '0;
        endcase
        case (aux_pat)
            0: aux_in = 1'b0;
            1: aux_in = 1'($urandom);
            2: aux_in = ~aux_in;
            default: aux_in = 1'b1;
        endcase
        trig_in  = (trig_div != 0) && ($urandom % trig_div == 0);
        host_clr = (clr_div != 0) && ($urandom % clr_div == 0);
    endtask

    task automatic run(input string req, input int n);
        cur_req = req;
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog got timeout exp completion");
            finish_up();
        end
    end

    initial begin
        ch_pat = 3;
        repeat (4) @(posedge clk);
        run("R11", 2);                      // R11: zero state under reset
        rst_n = 1'b1;
        run("R11", 3);                      // R11: zero state after reset
        // R1 / R10: random edges, live reads
        ch_pat = 0; run("R1", 300);
        // R1: held-high input counts once
        ch_pat = 2; run("R1", 20);
        ch_pat = 3; run("R1", 6);
        // R2: triggers latch while counting continues
        ch_pat = 0; trig_div = 6; run("R2", 400);
        // R3: narrow wrap, then wide carry, at max rate
        trig_div = 0; ch_pat = 1; cfg_wide = 1'b0; run("R3", 300);
        cfg_wide = 1'b1; run("R3", 300);
        trig_div = 9; run("R10", 100);
        // R4: auto-clear with coincident edges
        cfg_auto_rst = 1'b1; trig_div = 2; run("R4", 300);
        ch_pat = 0; trig_div = 5; run("R4", 300);
        cfg_auto_rst = 1'b0; trig_div = 7;
        // R12: aux ignored when off
        aux_pat = 1; cfg_aux_mode = 2'd0; run("R12", 300);
        // R5: freeze
        cfg_aux_mode = 2'd1; run("R5", 400);
        aux_pat = 3; run("R5", 60);
        // R6: test stimulus, with and without channel edges
        aux_pat = 2; cfg_aux_mode = 2'd2; ch_pat = 3; run("R6", 200);
        ch_pat = 1; run("R6", 200);
        ch_pat = 0; aux_pat = 1; run("R6", 300);
        // R7: aux clear
        cfg_aux_mode = 2'd3; run("R7", 400);
        cfg_aux_mode = 2'd0; aux_pat = 0;
        // R8: host clear pulses
        clr_div = 15; run("R8", 500);
        clr_div = 0;
        // R9: partial mask
        cfg_mask = 8'hA5; run("R9", 500);
        cfg_auto_rst = 1'b1; run("R9", 300);
        cfg_mask = '1; cfg_auto_rst = 1'b0;
        run("R2", 200);
        done = 1;
        finish_up();
    end
endmodule